// File: doc/BRIEF.md
# Challenge-Response Debug Access Gate

This block decides whether the debug port of a chip may be used. A fuse-loaded security field picks one of three policies: debug always open, debug opened only after a challenge-response exchange, or debug blocked. A separate kill fuse turns off every debug and boundary-scan function, whatever the other inputs say. A port select input chooses between the debug port and the manufacturing test port.

In the guarded policy, a simplified TAP front end provides two instructions. The first captures the 64-bit device unique ID and shifts it out on `tdo`, least significant bit first. The second shifts a 128-bit response in on `tdi`. On the update strobe after a full 128-bit shift, the response is compared with the stored key. Debug opens only on an exact match. A mismatch leaves the gate locked and raises a sticky fail flag. The stored key never reaches `tdo`.

Software can also open debug through a bypass bit. That bit has a sticky lock, and a fuse can disable its effect permanently. Any reset closes the gate again.

Top module: `dbg_auth_gate`

## Requirements
- R1: With `sec_fuse`=00, the kill fuse clear and `port_sel`=0, `dbg_en` is 1 and `test_en` is 0 with no authentication.
- R2: With `sec_fuse`=01, `dbg_en` stays 0 until authentication succeeds or the software bypass is active.
- R3: With `sec_fuse`=10 or 11, a correct response neither opens debug nor sets `auth_fail`. Only the software bypass can open debug.
- R4: With `kill_fuse`=1, `dbg_en`, `test_en` and `tdo` are all 0 in every mode. This includes the case where the correct response has been shifted in.
- R5: With `port_sel`=1, `test_en` is 1 and `dbg_en` is 0. With `port_sel`=0, `test_en` is 0.
- R6: `capture` with `instr`=01 loads the 64-bit `dev_uid`. Bit 0 is then on `tdo`, and each `shift` cycle with `instr`=01 moves the next higher bit onto `tdo`.
- R7: With `instr`=10, `capture` clears the response register and its bit count. Each `shift` cycle takes `tdi`, least significant bit first. An `update` after at least 128 shifts, in mode 01, compares the response with `resp_key`. On a match, `dbg_en` is 1 from the cycle after the update edge.
- R8: On a mismatch at such an update, `dbg_en` stays 0 and `auth_fail` becomes 1. `auth_fail` then stays 1 until reset, even if a later response succeeds.
- R9: An `update` after fewer than 128 response shifts changes neither the authentication state nor `auth_fail`.
- R10: `tdo` is 0 whenever `instr` is not 01, so the response register and the key are never observable.
- R11: Reset clears the authentication, `auth_fail`, the bypass bit and its lock.
- R12: `sw_de_wr` writes `sw_de_val` into the bypass bit. A set bit opens debug in any mode, provided `kill_fuse`=0 and `port_sel`=0.
- R13: After a `sw_lock_wr` pulse, further writes to the bypass bit are ignored until reset.
- R14: With `bypass_kill_fuse`=1, a set bypass bit does not open debug.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_fuse | input | 2 | Security field: 00 open, 01 challenge, 1x blocked |
| kill_fuse | input | 1 | Disables all debug and test functions |
| bypass_kill_fuse | input | 1 | Disables the software bypass |
| port_sel | input | 1 | 0 selects the debug port, 1 selects the test port |
| dev_uid | input | 64 | Device unique ID, used as the challenge |
| resp_key | input | 128 | Stored response key |
| instr | input | 2 | TAP instruction: 01 challenge, 10 response |
| capture | input | 1 | Capture strobe |
| shift | input | 1 | Shift strobe |
| update | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| sw_de_wr | input | 1 | Write strobe for the bypass bit |
| sw_de_val | input | 1 | Value written to the bypass bit |
| sw_lock_wr | input | 1 | Sets the sticky bypass lock |
| dbg_en | output | 1 | Debug access enable |
| test_en | output | 1 | Test port enable |
| auth_fail | output | 1 | Sticky failed-authentication flag |

## Verification
A wrong authentication flag shows on `dbg_en` in the cycle right after the update edge. A stuck or mis-ordered challenge register shows on `tdo` on the first shifted bit after capture. A bit counter that is off by one shows up in one of two ways: a short response is accepted, or a full one is ignored, at the next update. A bypass lock that leaks lets a later write change `dbg_en` one cycle after the write.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
    typedef enum logic [1:0] {
        INS_IDLE = 2'b00,
        INS_CHAL = 2'b01,
        INS_RESP = 2'b10,
        INS_RSVD = 2'b11
    } tap_ins_e;

    typedef enum logic [1:0] {
        SEC_OPEN    = 2'b00,
        SEC_GUARDED = 2'b01,
        SEC_BLOCKED = 2'b10
    } sec_mode_e;
endpackage

// File: rtl/dbg_mode_decode.sv
module dbg_mode_decode
    import dbg_gate_pkg::*;
(
    input  logic [1:0] sec_fuse,
    input  logic       kill_fuse,
    output sec_mode_e  mode,
    output logic       all_off
);
    always_comb begin
        unique case (sec_fuse)
            2'b00:   mode = SEC_OPEN;
            2'b01:   mode = SEC_GUARDED;
            default: mode = SEC_BLOCKED;
        endcase
        all_off = kill_fuse;
    end
endmodule

// File: rtl/dbg_chal_shifter.sv
module dbg_chal_shifter
    import dbg_gate_pkg::*;
#(
    parameter int UID_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       instr,
    input  logic             capture,
    input  logic             shift,
    input  logic [UID_W-1:0] uid,
    output logic             tdo_raw
);
    typedef struct packed {
        logic [UID_W-1:0] sr;
    } chal_st_t;

    chal_st_t st_d, st_q;
    logic     sel;

    always_comb begin
        sel  = (instr == INS_CHAL);
        st_d = st_q;
        if (sel && capture)
            st_d.sr = uid;
        else if (sel && shift)
            st_d.sr = {1'b0, st_q.sr[UID_W-1:1]};
        tdo_raw = sel ? st_q.sr[0] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    cap_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && capture) |=> ((instr != INS_CHAL) || (tdo_raw == $past(uid[0]))));
endmodule

// File: rtl/dbg_resp_checker.sv
module dbg_resp_checker
    import dbg_gate_pkg::*;
#(
    parameter int KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       instr,
    input  logic             capture,
    input  logic             shift,
    input  logic             update,
    input  logic             tdi,
    input  logic             armed,
    input  logic [KEY_W-1:0] key,
    output logic             authed,
    output logic             failed
);
    localparam int CNT_W = $clog2(KEY_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(KEY_W);

    typedef struct packed {
        logic [KEY_W-1:0] sr;
        logic [CNT_W-1:0] cnt;
        logic             authed;
        logic             failed;
    } resp_st_t;

    resp_st_t st_d, st_q;
    logic     sel, complete, match;

    always_comb begin
        sel      = (instr == INS_RESP);
        complete = (st_q.cnt == FULL);
        match    = (st_q.sr == key);
        st_d     = st_q;
        if (sel && capture) begin
            st_d.sr  = '0;
            st_d.cnt = '0;
        end else if (sel && shift) begin
            st_d.sr = {tdi, st_q.sr[KEY_W-1:1]};
            if (!complete) st_d.cnt = st_q.cnt + 1'b1;
        end else if (sel && update && complete) begin
            st_d.cnt = '0;
            if (armed) begin
                if (match) st_d.authed = 1'b1;
                else       st_d.failed = 1'b1;
            end
        end
        authed = st_q.authed;
        failed = st_q.failed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    auth_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(authed) |-> $past(update && sel && armed));
    // R11
    auth_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        authed |=> authed);
    // R8
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        failed |=> failed);
endmodule

// File: rtl/dbg_sw_bypass.sv
module dbg_sw_bypass (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic val,
    input  logic lock_wr,
    input  logic kill,
    output logic open
);
    typedef struct packed {
        logic de;
        logic lock;
    } byp_st_t;

    byp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && !st_q.lock) st_d.de = val;
        if (lock_wr)          st_d.lock = 1'b1;
        open = st_q.de && !kill;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R13
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> ($stable(st_q.de) && st_q.lock));
endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
    import dbg_gate_pkg::*;
#(
    parameter int UID_W = 64,
    parameter int KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sec_fuse,
    input  logic             kill_fuse,
    input  logic             bypass_kill_fuse,
    input  logic             port_sel,
    input  logic [UID_W-1:0] dev_uid,
    input  logic [KEY_W-1:0] resp_key,
    input  logic [1:0]       instr,
    input  logic             capture,
    input  logic             shift,
    input  logic             update,
    input  logic             tdi,
    output logic             tdo,
    input  logic             sw_de_wr,
    input  logic             sw_de_val,
    input  logic             sw_lock_wr,
    output logic             dbg_en,
    output logic             test_en,
    output logic             auth_fail
);
    sec_mode_e mode;
    logic      all_off, tdo_raw, authed, sw_open, armed;

    dbg_mode_decode u_decode (
        .sec_fuse (sec_fuse),
        .kill_fuse(kill_fuse),
        .mode     (mode),
        .all_off  (all_off)
    );

    dbg_chal_shifter #(.UID_W(UID_W)) u_chal (
        .clk    (clk),
        .rst_n  (rst_n),
        .instr  (instr),
        .capture(capture),
        .shift  (shift),
        .uid    (dev_uid),
        .tdo_raw(tdo_raw)
    );

    always_comb armed = (mode == SEC_GUARDED) && !all_off;

    dbg_resp_checker #(.KEY_W(KEY_W)) u_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .instr  (instr),
        .capture(capture),
        .shift  (shift),
        .update (update),
        .tdi    (tdi),
        .armed  (armed),
        .key    (resp_key),
        .authed (authed),
        .failed (auth_fail)
    );

    dbg_sw_bypass u_byp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (sw_de_wr),
        .val    (sw_de_val),
        .lock_wr(sw_lock_wr),
        .kill   (bypass_kill_fuse),
        .open   (sw_open)
    );

    always_comb begin
        dbg_en  = !all_off && !port_sel &&
                  ((mode == SEC_OPEN) || authed || sw_open);
        test_en = !all_off && port_sel;
        tdo     = all_off ? 1'b0 : tdo_raw;
    end

    // R5
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_en && test_en));
    // R10
    tdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr != INS_CHAL) |-> !tdo);
    // R4
    kill_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_fuse |-> (!dbg_en && !test_en && !tdo));
endmodule

// File: tb/test_dbg_auth_gate.sv
module test_dbg_auth_gate;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   sec_fuse;
    logic         kill_fuse, bypass_kill_fuse, port_sel;
    logic [63:0]  dev_uid;
    logic [127:0] resp_key;
    logic [1:0]   instr;
    logic         capture, shift, update, tdi, tdo;
    logic         sw_de_wr, sw_de_val, sw_lock_wr;
    logic         dbg_en, test_en, auth_fail;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [63:0]  UID = 64'hA5C3_0F1E_9B27_4D86;
    localparam logic [127:0] KEY = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    localparam logic [127:0] BAD = KEY ^ (128'h1 << 77);

    // {sec_fuse, kill, port_sel, exp_dbg, exp_test}
    localparam logic [5:0] VECS [0:7] = '{
        6'b00_0_0_1_0,   // R1 open, debug port
        6'b00_0_1_0_1,   // R5 open, test port
        6'b01_0_0_0_0,   // R2 guarded, locked
        6'b01_0_1_0_1,   // R5 guarded, test port
        6'b10_0_0_0_0,   // R3 blocked
        6'b11_0_0_0_0,   // R3 blocked
        6'b00_1_0_0_0,   // R4 kill, open mode
        6'b01_1_1_0_0    // R4 kill, test port
    };

    always #4 clk = ~clk;

    dbg_auth_gate i_dbg_auth_gate (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic pulse_cap(input logic [1:0] ins);
        instr = ins; capture = 1'b1;
        @(negedge clk) capture = 1'b0;
    endtask

    task automatic send_resp(input logic [127:0] v, input int n);
        pulse_cap(2'b10);
        for (int i = 0; i < n; i++) begin
            tdi = v[i]; shift = 1'b1;
            @(negedge clk);
        end
        shift = 1'b0; update = 1'b1;
        @(negedge clk) update = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] got;
        rst_n = 1'b0; sec_fuse = 2'b01; kill_fuse = 0; bypass_kill_fuse = 0; port_sel = 0;
        dev_uid = UID; resp_key = KEY; instr = 2'b00;
        capture = 0; shift = 0; update = 0; tdi = 0;
        sw_de_wr = 0; sw_de_val = 0; sw_lock_wr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset dbg_en", dbg_en, 0);
        chk("R11 reset auth_fail", auth_fail, 0);
        chk("R10 reset tdo", tdo, 0);

        // R1 R2 R3 R4 R5 table
        for (int v = 0; v < 8; v++) begin
            {sec_fuse, kill_fuse, port_sel} = VECS[v][5:2];
            #1;
            chk($sformatf("R1-5 table %0d dbg_en", v), dbg_en, VECS[v][1]);
            chk($sformatf("R1-5 table %0d test_en", v), test_en, VECS[v][0]);
            @(negedge clk);
        end
        sec_fuse = 2'b01; kill_fuse = 0; port_sel = 0;

        // R6 challenge readout
        pulse_cap(2'b01);
        got = '0;
        for (int i = 0; i < 64; i++) begin
            got[i] = tdo; shift = 1'b1;
            @(negedge clk);
        end
        shift = 1'b0;
        chk("R6 challenge", got, UID);
        pulse_cap(2'b01);
        instr = 2'b10; #1;
        chk("R10 tdo under response instr", tdo, 0);

        // R9 short response
        send_resp(KEY, 100);
        chk("R9 short dbg_en", dbg_en, 0);
        chk("R9 short auth_fail", auth_fail, 0);
        // R8 wrong response
        send_resp(BAD, 128);
        chk("R8 wrong dbg_en", dbg_en, 0);
        chk("R8 wrong auth_fail", auth_fail, 1);
        // R7 right response
        send_resp(KEY, 128);
        chk("R7 match dbg_en", dbg_en, 1);
        chk("R8 fail sticky", auth_fail, 1);
        port_sel = 1; #1;
        chk("R5 authed test port dbg_en", dbg_en, 0);
        chk("R5 authed test port test_en", test_en, 1);
        port_sel = 0;
        @(negedge clk);
        // R11 relock
        do_reset();
        chk("R11 relock dbg_en", dbg_en, 0);
        chk("R11 relock auth_fail", auth_fail, 0);

        // R3 blocked mode ignores response
        sec_fuse = 2'b10;
        send_resp(KEY, 128);
        chk("R3 blocked dbg_en", dbg_en, 0);
        chk("R3 blocked auth_fail", auth_fail, 0);

        // R4 kill fuse beats correct response
        sec_fuse = 2'b01; kill_fuse = 1;
        send_resp(KEY, 128);
        chk("R4 kill dbg_en", dbg_en, 0);
        pulse_cap(2'b01); #1;
        chk("R4 kill tdo", tdo, 0);
        kill_fuse = 0; #1;
        chk("R4 kill blocked auth", dbg_en, 0);
        @(negedge clk);
        do_reset();

        // R12 software bypass in blocked mode
        sec_fuse = 2'b10;
        sw_de_wr = 1; sw_de_val = 1;
        @(negedge clk) sw_de_wr = 0;
        chk("R12 bypass dbg_en", dbg_en, 1);
        // R14 kill of bypass
        bypass_kill_fuse = 1; #1;
        chk("R14 bypass killed", dbg_en, 0);
        bypass_kill_fuse = 0;
        // R13 lock
        sw_lock_wr = 1;
        @(negedge clk) sw_lock_wr = 0;
        sw_de_wr = 1; sw_de_val = 0;
        @(negedge clk) sw_de_wr = 0;
        chk("R13 locked write ignored", dbg_en, 1);
        do_reset();
        chk("R11 bypass cleared", dbg_en, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule